// File: doc/BRIEF.md
# Bus Clock Divider Factor Search

This block picks the two divider factors for a serial bus clock generator. One factor, N, runs from 0 to 7 and is a power-of-two stage. The other, M, runs from 0 to 15 and is a linear stage. The block is given the core clock frequency and the wanted bus frequency, both as unsigned integers in hertz. For a factor pair, the bus frequency that results is the integer quotient of the core clock divided by 10·(M+1)·2^(N+1).

A pulse on the start input latches both frequencies. The block then walks the factor pairs in a fixed order. For each pair it computes the resulting frequency with a bit-serial restoring divider. It keeps the pair whose result comes closest to the request without going above it. When the search ends, the block presents the chosen factors and a valid flag, and raises a one-cycle done pulse.

A pair whose result equals the request ends the search at once. If every pair overshoots the request, the block reports failure.

Top module: `baud_search`

## Requirements
- R1: The result for a pair (N, M) is floor(coreClk / (10·(M+1)·2^(N+1))), taken over the full 32-bit core clock value.
- R2: Pairs are tried with M as the inner index (0 to 15) and N as the outer index (0 to 7). A pair replaces the current best only when its difference is strictly smaller, so on a tie the pair tried first is kept.
- R3: A pair is eligible only when its result is less than or equal to the request. The difference is the request minus the result.
- R4: A difference of zero stops the search after that pair. The reported factors are that pair, with valid high.
- R5: When no pair gets a difference below 0xFFFFFFFF, the block ends with valid low and with factN and factM both 0.
- R6: done is high for exactly one cycle. If k pairs were tried, done is high 34·k+1 clock edges after the edge that captured start: 32 divide steps plus one load and one judge cycle per pair. For a full search, k is 128.
- R7: A start pulse while a search is running has no effect. The result and the timing are those of the search already running.
- R8: factN, factM and valid keep their values from one done pulse until the next start that is accepted. That start clears all three to 0.
- R9: After reset, done, valid, factN and factM are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a search when the block is idle |
| coreClk | input | 32 | Core clock frequency, latched on start |
| reqFreq | input | 32 | Requested bus frequency, latched on start |
| factN | output | 3 | Chosen power-of-two factor |
| factM | output | 4 | Chosen linear factor |
| valid | output | 1 | A qualifying pair was found |
| done | output | 1 | One-cycle pulse when the result is ready |

## Verification
Each search's outputs become valid together with done, which rises 34·k+1 edges after the start edge. The bench computes k from its own model of the search. It counts the edges from start to done, sampling on falling edges, and compares that count with 34·k+1. It reads the factors in the same half-cycle as done. It checks done low one cycle later, and it checks that the outputs are still unchanged several cycles after that. The clearing of the outputs on start is checked in the first falling edge after the start edge.

// File: rtl/baud_pkg.sv
package baud_pkg;
  typedef struct packed {
    logic capture;
    logic load;
    logic step;
    logic judge;
    logic publish;
  } dpCtrl_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_DIV,
    ST_EVAL,
    ST_FIN
  } srchState_t;
endpackage

// File: rtl/baud_ctrl.sv
module baud_ctrl
  import baud_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int N_W    = 3,
  parameter int M_W    = 4
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic           exact,
  output dpCtrl_t        ctl,
  output logic [N_W-1:0] candN,
  output logic [M_W-1:0] candM,
  output logic           busy
);
  localparam int CNT_W  = $clog2(DATA_W);
  localparam int PAIR_W = N_W + M_W;

  srchState_t        state;
  logic [CNT_W-1:0]  stepCnt;
  logic [PAIR_W-1:0] pairIdx;
  logic              lastPair;

  assign {candN, candM} = pairIdx;
  assign lastPair       = &pairIdx;
  assign busy           = (state != ST_IDLE);

  always_comb begin
    ctl         = '0;
    ctl.capture = (state == ST_IDLE) && start;
    ctl.load    = (state == ST_LOAD);
    ctl.step    = (state == ST_DIV);
    ctl.judge   = (state == ST_EVAL);
    ctl.publish = (state == ST_FIN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      pairIdx <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state   <= ST_LOAD;
          pairIdx <= '0;
        end
        ST_LOAD: begin
          state   <= ST_DIV;
          stepCnt <= '0;
        end
        ST_DIV: begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == CNT_W'(DATA_W - 1)) state <= ST_EVAL;
        end
        ST_EVAL: begin
          if (exact || lastPair) state <= ST_FIN;
          else begin
            pairIdx <= pairIdx + 1'b1;
            state   <= ST_LOAD;
          end
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/baud_dp.sv
module baud_dp
  import baud_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int N_W    = 3,
  parameter int M_W    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctl,
  input  logic [DATA_W-1:0] coreClk,
  input  logic [DATA_W-1:0] reqFreq,
  input  logic [N_W-1:0]    candN,
  input  logic [M_W-1:0]    candM,
  output logic              exact,
  output logic [N_W-1:0]    factN,
  output logic [M_W-1:0]    factM,
  output logic              valid,
  output logic              done
);
  logic [DATA_W-1:0] clkQ, reqQ, divisor, quot, bestDiff;
  logic [DATA_W:0]   remR, remShift;
  logic [DATA_W-1:0] mExt, tenM, divNext, diff;
  logic [N_W-1:0]    bestN;
  logic [M_W-1:0]    bestM;
  logic              bestHit, qualify, better, subOk;

  // divisor = 10*(M+1) << (N+1), built from shifts and adds
  always_comb begin
    mExt    = DATA_W'(candM) + 1'b1;
    tenM    = (mExt << 3) + (mExt << 1);
    divNext = (tenM << 1) << candN;
  end

  assign remShift = {remR[DATA_W-1:0], quot[DATA_W-1]};
  assign subOk    = (remShift >= {1'b0, divisor});
  assign qualify  = (quot <= reqQ);
  assign diff     = reqQ - quot;
  assign better   = qualify && (diff < bestDiff);
  assign exact    = qualify && (diff == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkQ     <= '0;
      reqQ     <= '0;
      divisor  <= '0;
      quot     <= '0;
      remR     <= '0;
      bestDiff <= '1;
      bestN    <= '0;
      bestM    <= '0;
      bestHit  <= 1'b0;
      factN    <= '0;
      factM    <= '0;
      valid    <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (ctl.capture) begin
        clkQ     <= coreClk;
        reqQ     <= reqFreq;
        bestDiff <= '1;
        bestN    <= '0;
        bestM    <= '0;
        bestHit  <= 1'b0;
        factN    <= '0;
        factM    <= '0;
        valid    <= 1'b0;
      end
      if (ctl.load) begin
        divisor <= divNext;
        quot    <= clkQ;
        remR    <= '0;
      end
      if (ctl.step) begin
        if (subOk) begin
          remR <= remShift - {1'b0, divisor};
          quot <= {quot[DATA_W-2:0], 1'b1};
        end else begin
          remR <= remShift;
          quot <= {quot[DATA_W-2:0], 1'b0};
        end
      end
      if (ctl.judge && better) begin
        bestDiff <= diff;
        bestN    <= candN;
        bestM    <= candM;
        bestHit  <= 1'b1;
      end
      if (ctl.publish) begin
        factN <= bestN;
        factM <= bestM;
        valid <= bestHit;
        done  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/baud_search.sv
module baud_search
  import baud_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int N_W    = 3,
  parameter int M_W    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [DATA_W-1:0] coreClk,
  input  logic [DATA_W-1:0] reqFreq,
  output logic [N_W-1:0]    factN,
  output logic [M_W-1:0]    factM,
  output logic              valid,
  output logic              done
);
  dpCtrl_t        ctl;
  logic [N_W-1:0] candN;
  logic [M_W-1:0] candM;
  logic           exact;
  logic           busy;

  baud_ctrl #(.DATA_W(DATA_W), .N_W(N_W), .M_W(M_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .exact(exact),
    .ctl(ctl), .candN(candN), .candM(candM), .busy(busy)
  );

  baud_dp #(.DATA_W(DATA_W), .N_W(N_W), .M_W(M_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .coreClk(coreClk), .reqFreq(reqFreq),
    .candN(candN), .candM(candM), .exact(exact),
    .factN(factN), .factM(factM), .valid(valid), .done(done)
  );
endmodule

// File: rtl/baud_search_chk.sv
module baud_search_chk #(
  parameter int N_W = 3,
  parameter int M_W = 4
) (
  input logic           clk,
  input logic           rstN,
  input logic           start,
  input logic           busy,
  input logic [N_W-1:0] factN,
  input logic [M_W-1:0] factM,
  input logic           valid,
  input logic           done
);
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(busy));

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable({factN, factM, valid}) |-> (done || $past(start)));

  // R5
  fail_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !valid) |-> (factN == '0 && factM == '0));
endmodule

bind baud_search baud_search_chk #(.N_W(N_W), .M_W(M_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy),
  .factN(factN), .factM(factM), .valid(valid), .done(done)
);

// File: tb/baud_search_tb.sv
module baud_search_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] coreClk = '0;
  logic [31:0] reqFreq = '0;
  logic [2:0]  factN;
  logic [3:0]  factM;
  logic        valid, done;
  int          checks = 0;
  int          errors = 0;
  int          cycles = 0;

  always #10 clk = ~clk;

  baud_search u_dut (
    .clk(clk), .rstN(rstN), .start(start), .coreClk(coreClk), .reqFreq(reqFreq),
    .factN(factN), .factM(factM), .valid(valid), .done(done)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void model(input longint unsigned c, input longint unsigned r,
                                output int en, output int em, output bit ef,
                                output int cnt);
    longint unsigned best = 64'hFFFF_FFFF;
    en = 0; em = 0; ef = 0; cnt = 0;
    for (int n = 0; n < 8; n++) begin
      for (int m = 0; m < 16; m++) begin
        longint unsigned d = longint'(10 * (m + 1)) * (longint'(2) << n);
        longint unsigned q = c / d;
        cnt++;
        if (q <= r) begin
          if (r - q < best) begin
            best = r - q; en = n; em = m; ef = 1;
          end
          if (r - q == 0) return;
        end
      end
    end
  endfunction

  // Runs one search; injectAt >= 0 pulses start again mid-search with other inputs.
  task automatic runSearch(input string name, input logic [31:0] c,
                           input logic [31:0] r, input int injectAt);
    int en, em, cnt, lat;
    bit ef;
    logic [6:0] held;
    model(c, r, en, em, ef, cnt);
    @(negedge clk);
    coreClk = c; reqFreq = r; start = 1'b1;
    @(posedge clk);
    lat = 0;
    forever begin
      @(negedge clk);
      start = 1'b0;
      if (lat == 0)
        chk(!valid && factN == 0 && factM == 0, "R8", {name, " cleared on start"},
            {factN, factM, valid}, 0);
      if (lat == injectAt) begin
        start = 1'b1; coreClk = ~c; reqFreq = r >> 1;
      end
      if (done || lat > 5000) break;
      @(posedge clk);
      lat++;
    end
    chk(lat == 34 * cnt + 1, "R6", {name, " done latency"}, lat, 34 * cnt + 1);
    chk(valid == ef, "R3/R5", {name, " valid"}, valid, ef);
    chk(factN == en[2:0] && factM == em[3:0], "R1/R2/R4", {name, " factors {N,M}"},
        {factN, factM}, {en[2:0], em[3:0]});
    held = {factN, factM, valid};
    @(negedge clk);
    chk(!done, "R6", {name, " done one cycle"}, done, 0);
    repeat (5) @(negedge clk);
    chk({factN, factM, valid} == held, "R8", {name, " outputs held"},
        {factN, factM, valid}, held);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!done && !valid && factN == 0 && factM == 0, "R9", "reset outputs",
        {done, valid, factN, factM}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(!done && !valid, "R9", "idle after reset", {done, valid}, 0);

    // R4 exact on the very first pair: 100e6/20 = 5e6
    runSearch("exact_first", 32'd100_000_000, 32'd5_000_000, -1);
    // R4 exact found later in the order
    runSearch("exact_later", 32'd960_000, 32'd1000, -1);
    // R1 R3 typical full search
    runSearch("typical", 32'd166_666_667, 32'd100_000, -1);
    runSearch("fast_bus", 32'd200_000_000, 32'd400_000, -1);
    // R2 tie: n0m1 and n1m0 both give 2, the first tried wins
    runSearch("tie", 32'd100, 32'd3, -1);
    // R5 no pair fits
    runSearch("not_found", 32'd100_000_000, 32'd1, -1);
    // R1 full-width operands
    runSearch("full_width", 32'hFFFF_FFFF, 32'hFFFF_FFFF, -1);
    // R7 start while busy is ignored
    runSearch("busy_start", 32'd166_666_667, 32'd100_000, 100);
    runSearch("after_ignore", 32'd50_000_000, 32'd97_000, -1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule